// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block holds the small set of control and status registers that sit beside the I/O subsystem of a workstation. There are three plain byte registers: configuration, diagnostic and modem control. There are two byte registers whose writes have side effects: misc functions and power control. A 32-bit system-control word and a 16-bit LED word complete the bank. A one-hot select vector picks the register. A small offset input addresses positions inside the wider windows. Writes take effect on the rising clock edge. Read data is a combinational function of the select, the offset and the stored state.

The bank turns some register writes into actions. Writing the misc register with its terminal-count bit set sends a one-cycle pulse to the floppy controller, and the bit is not stored. A power-failing input sets a sticky status bit, but only while the power-interrupt enable is on. A write-one to the power register clears that bit. The power-fail interrupt is the AND of that status bit and the enable. Writing the power-off bit, or the reset bit of the system-control word, produces a one-cycle request pulse. The reset bit also leaves a reset-status flag behind.

Two resets are provided, both synchronous and active-high. The ordinary reset clears only the configuration, misc, power and modem registers. The power-on reset clears every register.

Top module: `aux_ctrl_bank`

## Requirements
- R1: With `regSel` one-hot (bit 0 configuration, 1 diagnostic, 2 modem, 3 misc, 4 power, 5 system control, 6 LED), a write stores the low 8 bits of `wrData` into the configuration, diagnostic or modem register, and a read returns them zero-extended on `rdData`; with no select bit set `rdData` is zero.
- R2: `rst` clears the configuration, misc, power and modem registers and leaves the diagnostic, system-control and LED registers unchanged; `porRst` clears all seven registers and all outputs.
- R3: A misc write with data bit 1 set makes `tcPulse` high for exactly the one cycle after the write edge; the misc register stores the data with bit 1 forced to zero, and a write with bit 1 clear gives no pulse.
- R4: A power-register write takes only data bits 0 (power off) and 1 (clear) and keeps the current bit 5 (power-fail status); if data bit 1 is one, all bits except bit 0 are cleared; bit 1 always reads back as zero and bits 2-4, 6, 7 read zero.
- R5: A power-register write with data bit 0 set stores bit 0 and makes `pwrOffReq` high for exactly the one cycle after the write edge.
- R6: At the first clock edge at which `pfIn` differs from its value at the previous edge, power-register bit 5 becomes one if `pfIn` is one and configuration bit 3 is set; otherwise it becomes zero. This event overrides a power-register write in the same cycle.
- R7: `pwrIrq` is high exactly when power-register bit 5 and configuration bit 3 are both set, and it follows every configuration write, power write and `pfIn` event in the cycle after that edge.
- R8: A system-control write at offset 0 with data bit 0 set loads the word with 0x00000002 and makes `sysRstReq` high for one cycle; a write at offset 0 with bit 0 clear changes nothing and gives no pulse.
- R9: The LED register is written with `wrData[15:0]` and read back at offset 0. For the LED and system-control windows, reads at a non-zero `regOfs` return zero, and writes there change no register and give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of configuration, misc, power and modem registers |
| porRst | input | 1 | Synchronous power-on reset of every register |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| regSel | input | 7 | One-hot register select |
| regOfs | input | 2 | Offset within the selected window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |
| pfIn | input | 1 | Power-failing indication from outside |
| pwrIrq | output | 1 | Power-fail interrupt |
| tcPulse | output | 1 | One-cycle floppy terminal-count pulse |
| pwrOffReq | output | 1 | One-cycle power-off request |
| sysRstReq | output | 1 | One-cycle system-reset request |

## Verification
The bench checks that the terminal-count bit never reads back and never repeats its pulse. A design that stored the bit would read 0xFF instead of 0xFD. It checks that the power-fail status survives an unrelated power write and a disabled interrupt enable, and that it disappears on the clear bit. A design that took the whole data byte, or dropped bit 5, would read back a wrong power value or lose `pwrIrq` when the enable comes back. It checks that a `pfIn` change while the enable is off clears the status rather than setting it, and that the split reset keeps the diagnostic, system-control and LED contents. It also checks that writes at a non-zero offset in the wide windows neither load the 0x2 status nor raise `sysRstReq`.

// File: rtl/aux_bank_pkg.sv
package aux_bank_pkg;
  localparam int SEL_N    = 7;
  localparam int SEL_CFG  = 0;
  localparam int SEL_DIAG = 1;
  localparam int SEL_MDM  = 2;
  localparam int SEL_MISC = 3;
  localparam int SEL_PWR  = 4;
  localparam int SEL_SYS  = 5;
  localparam int SEL_LED  = 6;

  // bit positions whose meaning the block depends on
  localparam int CFG_IRQEN_BIT = 3;
  localparam int MISC_TC_BIT   = 1;
  localparam int PWR_OFF_BIT   = 0;
  localparam int PWR_CLR_BIT   = 1;
  localparam int PWR_FAIL_BIT  = 5;
  localparam int SYS_REQ_BIT   = 0;
  localparam int SYS_STAT_BIT  = 1;
  localparam int CMD_W         = 2;

  typedef struct packed {
    logic wrCfg;
    logic wrDiag;
    logic wrMdm;
    logic wrMisc;
    logic wrPwr;
    logic wrSys;
    logic wrLed;
    logic pfEvent;
  } strobe_t;
endpackage

// File: rtl/aux_bank_ctrl.sv
module aux_bank_ctrl
  import aux_bank_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             porRst,
  input  logic             wrEn,
  input  logic [SEL_N-1:0] regSel,
  input  logic [OFS_W-1:0] regOfs,
  input  logic [CMD_W-1:0] cmdBits,
  input  logic             pfIn,
  output strobe_t          stb,
  output logic             tcPulse,
  output logic             pwrOffReq,
  output logic             sysRstReq
);
  logic atZero;
  logic pfPrev;
  logic anyRst;

  assign atZero = (regOfs == '0);
  assign anyRst = rst | porRst;

  always_comb begin
    stb.wrCfg   = wrEn & regSel[SEL_CFG];
    stb.wrDiag  = wrEn & regSel[SEL_DIAG];
    stb.wrMdm   = wrEn & regSel[SEL_MDM];
    stb.wrMisc  = wrEn & regSel[SEL_MISC];
    stb.wrPwr   = wrEn & regSel[SEL_PWR];
    stb.wrSys   = wrEn & regSel[SEL_SYS] & atZero & cmdBits[SYS_REQ_BIT];
    stb.wrLed   = wrEn & regSel[SEL_LED] & atZero;
    stb.pfEvent = (pfIn != pfPrev);
  end

  always_ff @(posedge clk) begin
    if (anyRst) begin
      pfPrev    <= 1'b0;
      tcPulse   <= 1'b0;
      pwrOffReq <= 1'b0;
      sysRstReq <= 1'b0;
    end else begin
      pfPrev    <= pfIn;
      tcPulse   <= stb.wrMisc & cmdBits[MISC_TC_BIT];
      pwrOffReq <= stb.wrPwr & cmdBits[PWR_OFF_BIT];
      sysRstReq <= stb.wrSys;
    end
  end
endmodule

// File: rtl/aux_bank_regs.sv
module aux_bank_regs
  import aux_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int BYTE_W = 8,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              porRst,
  input  strobe_t           stb,
  input  logic [LED_W-1:0]  wrData,
  input  logic              pfIn,
  input  logic [SEL_N-1:0]  regSel,
  input  logic [OFS_W-1:0]  regOfs,
  output logic [DATA_W-1:0] rdData,
  output logic              pwrIrq
);
  localparam logic [DATA_W-1:0] SYS_LOAD = DATA_W'(1) << SYS_STAT_BIT;

  logic [BYTE_W-1:0] cfgQ, diagQ, mdmQ, miscQ, pwrQ, pwrNext;
  logic [DATA_W-1:0] sysQ;
  logic [LED_W-1:0]  ledQ;
  logic              keepOff;
  logic              wideOk;

  // power register next state: write first, then the input event
  always_comb begin
    pwrNext = pwrQ;
    keepOff = 1'b0;
    if (stb.wrPwr) begin
      pwrNext               = '0;
      pwrNext[PWR_OFF_BIT]  = wrData[PWR_OFF_BIT];
      pwrNext[PWR_FAIL_BIT] = pwrQ[PWR_FAIL_BIT];
      if (wrData[PWR_CLR_BIT]) begin
        keepOff              = pwrNext[PWR_OFF_BIT];
        pwrNext              = '0;
        pwrNext[PWR_OFF_BIT] = keepOff;
      end
    end
    if (stb.pfEvent)
      pwrNext[PWR_FAIL_BIT] = pfIn & cfgQ[CFG_IRQEN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst || porRst) begin
      cfgQ  <= '0;
      mdmQ  <= '0;
      miscQ <= '0;
      pwrQ  <= '0;
    end else begin
      if (stb.wrCfg) cfgQ <= wrData[BYTE_W-1:0];
      if (stb.wrMdm) mdmQ <= wrData[BYTE_W-1:0];
      if (stb.wrMisc) begin
        miscQ              <= wrData[BYTE_W-1:0];
        miscQ[MISC_TC_BIT] <= 1'b0;
      end
      pwrQ <= pwrNext;
    end
  end

  // registers that only the power-on reset clears
  always_ff @(posedge clk) begin
    if (porRst) begin
      diagQ <= '0;
      sysQ  <= '0;
      ledQ  <= '0;
    end else begin
      if (stb.wrDiag) diagQ <= wrData[BYTE_W-1:0];
      if (stb.wrSys)  sysQ  <= SYS_LOAD;
      if (stb.wrLed)  ledQ  <= wrData;
    end
  end

  assign pwrIrq = pwrQ[PWR_FAIL_BIT] & cfgQ[CFG_IRQEN_BIT];
  assign wideOk = (regOfs == '0);

  always_comb begin
    rdData = '0;
    if (regSel[SEL_CFG])  rdData[BYTE_W-1:0] = cfgQ;
    if (regSel[SEL_DIAG]) rdData[BYTE_W-1:0] = diagQ;
    if (regSel[SEL_MDM])  rdData[BYTE_W-1:0] = mdmQ;
    if (regSel[SEL_MISC]) rdData[BYTE_W-1:0] = miscQ;
    if (regSel[SEL_PWR])  rdData[BYTE_W-1:0] = pwrQ;
    if (regSel[SEL_SYS] && wideOk) rdData = sysQ;
    if (regSel[SEL_LED] && wideOk) rdData[LED_W-1:0] = ledQ;
  end
endmodule

// File: rtl/aux_ctrl_bank.sv
module aux_ctrl_bank
  import aux_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int BYTE_W = 8,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              porRst,
  input  logic              wrEn,
  input  logic [SEL_N-1:0]  regSel,
  input  logic [OFS_W-1:0]  regOfs,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              pfIn,
  output logic              pwrIrq,
  output logic              tcPulse,
  output logic              pwrOffReq,
  output logic              sysRstReq
);
  strobe_t stb;
  logic    unusedHi;

  assign unusedHi = ^wrData[DATA_W-1:LED_W];

  aux_bank_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rst(rst), .porRst(porRst), .wrEn(wrEn), .regSel(regSel),
    .regOfs(regOfs), .cmdBits(wrData[CMD_W-1:0]), .pfIn(pfIn), .stb(stb),
    .tcPulse(tcPulse), .pwrOffReq(pwrOffReq), .sysRstReq(sysRstReq)
  );

  aux_bank_regs #(.DATA_W(DATA_W), .LED_W(LED_W), .BYTE_W(BYTE_W), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst(rst), .porRst(porRst), .stb(stb), .wrData(wrData[LED_W-1:0]),
    .pfIn(pfIn), .regSel(regSel), .regOfs(regOfs), .rdData(rdData), .pwrIrq(pwrIrq)
  );
endmodule

// File: rtl/aux_bank_chk.sv
module aux_bank_chk
  import aux_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              porRst,
  input logic              wrEn,
  input logic [SEL_N-1:0]  regSel,
  input logic [OFS_W-1:0]  regOfs,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              pfIn,
  input logic              pwrIrq,
  input logic              tcPulse,
  input logic              pwrOffReq,
  input logic              sysRstReq
);
  a_r3_tc_fires: assert property (@(posedge clk) disable iff (rst || porRst)
    wrEn && regSel[SEL_MISC] && wrData[MISC_TC_BIT] |=> tcPulse);
  a_r3_tc_cause: assert property (@(posedge clk) disable iff (rst || porRst)
    tcPulse |-> $past(wrEn && regSel[SEL_MISC] && wrData[MISC_TC_BIT]));
  a_r3_tc_unread: assert property (@(posedge clk) disable iff (rst || porRst)
    regSel == SEL_N'(1 << SEL_MISC) |-> !rdData[MISC_TC_BIT]);
  a_r4_clr_unread: assert property (@(posedge clk) disable iff (rst || porRst)
    regSel == SEL_N'(1 << SEL_PWR) |-> !rdData[PWR_CLR_BIT]);
  a_r5_off_fires: assert property (@(posedge clk) disable iff (rst || porRst)
    wrEn && regSel[SEL_PWR] && wrData[PWR_OFF_BIT] |=> pwrOffReq);
  a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst || porRst)
    regSel == SEL_N'(1 << SEL_CFG) && !rdData[CFG_IRQEN_BIT] |-> !pwrIrq);
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst || porRst)
    $rose(pwrIrq) |-> $past(wrEn && regSel[SEL_CFG]) || ($past(pfIn) && !$past(pfIn, 2)));
  a_r8_req_fires: assert property (@(posedge clk) disable iff (rst || porRst)
    wrEn && regSel[SEL_SYS] && regOfs == '0 && wrData[SYS_REQ_BIT] |=> sysRstReq);
  a_r9_wide_zero: assert property (@(posedge clk) disable iff (rst || porRst)
    (regSel[SEL_SYS] || regSel[SEL_LED]) && $onehot0(regSel) && regOfs != '0 |-> rdData == '0);
endmodule

bind aux_ctrl_bank aux_bank_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst(rst), .porRst(porRst), .wrEn(wrEn), .regSel(regSel),
  .regOfs(regOfs), .wrData(wrData), .rdData(rdData), .pfIn(pfIn),
  .pwrIrq(pwrIrq), .tcPulse(tcPulse), .pwrOffReq(pwrOffReq), .sysRstReq(sysRstReq)
);

// File: tb/aux_ctrl_bank_tb.sv
module aux_ctrl_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CFG = 0, DIAG = 1, MDM = 2, MISC = 3, PWR = 4, SYS = 5, LED = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1, porRst = 1'b1, wrEn = 1'b0, pfIn = 1'b0;
  logic [6:0]  regSel = '0;
  logic [1:0]  regOfs = '0;
  logic [31:0] wrData = '0, rdData;
  logic        pwrIrq, tcPulse, pwrOffReq, sysRstReq;
  int          nRun = 0, nFail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  aux_ctrl_bank u_dut (
    .clk(clk), .rst(rst), .porRst(porRst), .wrEn(wrEn), .regSel(regSel),
    .regOfs(regOfs), .wrData(wrData), .rdData(rdData), .pfIn(pfIn),
    .pwrIrq(pwrIrq), .tcPulse(tcPulse), .pwrOffReq(pwrOffReq), .sysRstReq(sysRstReq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // write on one edge; returns at the following negedge with the pulse window open
  task automatic wr(int sel, logic [1:0] ofs, logic [31:0] d);
    @(negedge clk);
    regSel = 7'(1 << sel); regOfs = ofs; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; regSel = '0; regOfs = '0;
  endtask

  task automatic rd(int sel, logic [1:0] ofs, output logic [31:0] d);
    regSel = 7'(1 << sel); regOfs = ofs; #1;
    d = rdData;
    regSel = '0; regOfs = '0;
  endtask

  task automatic setPf(logic v);
    @(negedge clk); pfIn = v; @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int s = 0; s < 7; s++) begin rd(s, 2'd0, d); check("R2 por clears", d, 0); end
    check("R2 outputs idle", {pwrIrq, tcPulse, pwrOffReq, sysRstReq}, 0);
    #1 check("R1 no select reads zero", rdData, 0);
  endtask

  task automatic t_bytes;
    logic [31:0] d;
    wr(DIAG, 2'd0, 32'hFFFF_FF3C); wr(MDM, 2'd0, 32'h0000_00C3); wr(CFG, 2'd0, 32'h0000_0051);
    rd(DIAG, 2'd0, d); check("R1 diag", d, 32'h3C);
    rd(MDM, 2'd0, d);  check("R1 modem", d, 32'hC3);
    rd(CFG, 2'd0, d);  check("R1 config", d, 32'h51);
    wr(CFG, 2'd0, 32'h0);
  endtask

  task automatic t_misc;
    logic [31:0] d;
    wr(MISC, 2'd0, 32'hFF);
    check("R3 tc pulse high", tcPulse, 1);
    @(negedge clk); check("R3 tc pulse single", tcPulse, 0);
    rd(MISC, 2'd0, d); check("R3 tc bit not stored", d, 32'hFD);
    wr(MISC, 2'd0, 32'h40);
    check("R3 no pulse without bit", tcPulse, 0);
    rd(MISC, 2'd0, d); check("R3 misc value", d, 32'h40);
  endtask

  task automatic t_pwrfail;
    logic [31:0] d;
    wr(CFG, 2'd0, 32'h08);
    setPf(1'b1);
    rd(PWR, 2'd0, d); check("R6 status set", d, 32'h20);
    check("R7 irq raised", pwrIrq, 1);
    wr(CFG, 2'd0, 32'h00); check("R7 irq masked", pwrIrq, 0);
    rd(PWR, 2'd0, d); check("R4 status kept while masked", d, 32'h20);
    wr(CFG, 2'd0, 32'h08); check("R7 irq back", pwrIrq, 1);
    wr(PWR, 2'd0, 32'hDC);
    rd(PWR, 2'd0, d); check("R4 only low bits taken", d, 32'h20);
    wr(PWR, 2'd0, 32'h02);
    rd(PWR, 2'd0, d); check("R4 clear bit", d, 32'h00);
    check("R7 irq after clear", pwrIrq, 0);
    setPf(1'b0);
    setPf(1'b1);
    rd(PWR, 2'd0, d); check("R6 set again", d, 32'h20);
    setPf(1'b0);
    rd(PWR, 2'd0, d); check("R6 falling input clears", d, 32'h00);
    wr(CFG, 2'd0, 32'h00);
    setPf(1'b1);
    rd(PWR, 2'd0, d); check("R6 disabled no set", d, 32'h00);
    wr(CFG, 2'd0, 32'h08); check("R7 no stale irq", pwrIrq, 0);
    setPf(1'b0);
  endtask

  task automatic t_pwroff;
    logic [31:0] d;
    wr(PWR, 2'd0, 32'h01);
    check("R5 off pulse", pwrOffReq, 1);
    @(negedge clk); check("R5 off single", pwrOffReq, 0);
    rd(PWR, 2'd0, d); check("R5 off stored", d, 32'h01);
    wr(PWR, 2'd0, 32'h03);
    check("R5 off pulse with clear", pwrOffReq, 1);
    rd(PWR, 2'd0, d); check("R4 clear keeps bit0", d, 32'h01);
  endtask

  task automatic t_sys;
    logic [31:0] d;
    wr(SYS, 2'd0, 32'hFFFF_FFFE);
    check("R8 no pulse bit0 clear", sysRstReq, 0);
    rd(SYS, 2'd0, d); check("R8 unchanged", d, 0);
    wr(SYS, 2'd2, 32'h1);
    check("R9 offset write no pulse", sysRstReq, 0);
    rd(SYS, 2'd0, d); check("R9 offset write ignored", d, 0);
    wr(SYS, 2'd0, 32'h1);
    check("R8 reset pulse", sysRstReq, 1);
    @(negedge clk); check("R8 reset single", sysRstReq, 0);
    rd(SYS, 2'd0, d); check("R8 status flag", d, 32'h2);
    rd(SYS, 2'd1, d); check("R9 sys offset read", d, 0);
  endtask

  task automatic t_led;
    logic [31:0] d;
    wr(LED, 2'd0, 32'h5A5A_BEEF);
    rd(LED, 2'd0, d); check("R9 led value", d, 32'hBEEF);
    wr(LED, 2'd1, 32'h1234);
    rd(LED, 2'd0, d); check("R9 led offset write ignored", d, 32'hBEEF);
    rd(LED, 2'd3, d); check("R9 led offset read", d, 0);
  endtask

  task automatic t_split_reset;
    logic [31:0] d;
    wr(CFG, 2'd0, 32'h08); wr(MDM, 2'd0, 32'h77); wr(MISC, 2'd0, 32'h44);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd(CFG, 2'd0, d);  check("R2 cfg cleared", d, 0);
    rd(MDM, 2'd0, d);  check("R2 modem cleared", d, 0);
    rd(MISC, 2'd0, d); check("R2 misc cleared", d, 0);
    rd(PWR, 2'd0, d);  check("R2 power cleared", d, 0);
    rd(DIAG, 2'd0, d); check("R2 diag kept", d, 32'h3C);
    rd(SYS, 2'd0, d);  check("R2 sys kept", d, 32'h2);
    rd(LED, 2'd0, d);  check("R2 led kept", d, 32'hBEEF);
    @(negedge clk); porRst = 1'b1; @(negedge clk); porRst = 1'b0;
    rd(DIAG, 2'd0, d); check("R2 por diag", d, 0);
    rd(SYS, 2'd0, d);  check("R2 por sys", d, 0);
    rd(LED, 2'd0, d);  check("R2 por led", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; porRst = 1'b0;
    t_reset();
    t_bytes();
    t_misc();
    t_pwrfail();
    t_pwroff();
    t_sys();
    t_led();
    t_split_reset();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule